// File: doc/BRIEF.md
# NAND Program/Erase Completion Waiter

This block takes over once a program or erase operation has already been sent to a NAND flash device. On a start pulse it sends one status-read opcode to the flash command path and waits a short settling window. It then watches for the operation to finish and returns one status byte as the result.

Completion comes from one of two sources. When the board wires the ready/busy pin, the block watches that pin through a synchroniser. When the pin is absent, the block polls status bytes until the ready bit is set. A watchdog window runs from the start pulse, and its length depends on the operation: 400 ms for an erase and 20 ms for a program, both counted in clock ticks. If the window closes first, the block reports a fixed failure code instead of a device status.

The command byte leaves on a valid/ready stream. `cmd_valid_o` stays high with a stable byte until the downstream side accepts it with `cmd_ready_i`. Status bytes arrive on a second valid/ready stream. A byte is consumed only in a cycle where both `st_valid_i` and `st_ready_o` are high. The block raises `st_ready_o` only while it wants a byte, so the source may hold a byte back for as long as it needs. Start, flags, the pin, the done pulse and the result are plain control signals.

Top module: `nand_done_waiter`

## Requirements
- R1: After an accepted start, the block drives exactly one command byte with `cmd_valid_o` high. While `cmd_ready_i` is low, `cmd_valid_o` stays high and the byte stays unchanged. `cmd_valid_o` drops after the handshake.
- R2: The command byte is 0x71 when the start was an erase (`erase_i`=1) with `multi_status_i`=1. In every other case it is 0x70. Both flags are sampled on the start cycle.
- R3: No ready condition is acted on until TWB_CYCLES cycles after the command handshake. A device that already shows ready finishes no sooner than TWB_CYCLES+3 cycles after the start edge.
- R4: With `rb_present_i`=1, completion is taken from `rb_i` (1 = ready) after RB_SYNC_STAGES synchroniser flops. Status bytes do not end the wait in this mode, even if their bit 6 is set.
- R5: With `rb_present_i`=0, the block takes status bytes while polling. Polling ends on the first byte whose bit 6 (mask 0x40) is 1. Bytes with bit 6 clear are consumed and dropped. `rb_i` has no effect in this mode.
- R6: After completion is seen, the block takes one further status byte and returns it unchanged on `result_o`. Bit 0 of that byte, the pass/fail flag, is passed through untouched.
- R7: The window is PROG_MS×TICKS_PER_MS clock edges for a program and ERASE_MS×TICKS_PER_MS for an erase, counted from the start edge. If the window closes before completion is seen (a timeout wins a tie), `result_o` is 0x01.
- R8: `done_o` is high for exactly one cycle per operation, and `result_o` is valid in that cycle and held afterwards.
- R9: A start pulse while an operation is in progress, including the cycle with `done_o` high, is ignored. The window restarts from zero on every accepted start.
- R10: After reset, `done_o`, `cmd_valid_o` and `st_ready_o` are 0, and `result_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| erase_i | input | 1 | 1 = operation was an erase, 0 = program |
| multi_status_i | input | 1 | Selects the multi-plane status opcode for erases |
| rb_present_i | input | 1 | 1 = ready/busy pin is wired and used |
| rb_i | input | 1 | Ready/busy pin, 1 = ready |
| cmd_valid_o | output | 1 | Command byte valid |
| cmd_ready_i | input | 1 | Command byte accepted |
| cmd_byte_o | output | 8 | Status opcode |
| st_valid_i | input | 1 | Status byte valid |
| st_ready_o | output | 1 | Block takes a status byte |
| st_byte_i | input | 8 | Status byte from the device |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 8 | Final status or 0x01 on timeout |

## Verification
The properties assume that `rb_present_i` is held steady for the whole of an operation. They also assume the window is longer than TWB_CYCLES+3 cycles, so a timeout cannot land before the settling floor. The bench changes the pin-present flag only between operations, runs with short tick rates that still keep the window well above that floor, and holds `st_valid_i` high so the status stream never stalls.

// File: rtl/ndw_pkg.sv
package ndw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_SETTLE,
    ST_POLL,
    ST_FETCH,
    ST_REPORT
  } ndw_state_e;

  localparam logic [7:0] OPC_STATUS    = 8'h70;
  localparam logic [7:0] OPC_STATUS_MP = 8'h71;
  localparam logic [7:0] RES_TIMEOUT   = 8'h01;
  localparam int unsigned RDY_BIT      = 6;

  function automatic logic [7:0] pick_opcode(input logic erase, input logic multi);
    return (erase && multi) ? OPC_STATUS_MP : OPC_STATUS;
  endfunction
endpackage

// File: rtl/ndw_sync.sv
module ndw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES:0] chain;
  assign chain[0] = d_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g+1] <= 1'b0;
      else        chain[g+1] <= chain[g];
    end
  end

  assign q_o = chain[STAGES];
endmodule

// File: rtl/ndw_timeout.sv
module ndw_timeout #(
  parameter int PROG_TICKS  = 2000000,
  parameter int ERASE_TICKS = 40000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic erase_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int MAX_TICKS = (ERASE_TICKS > PROG_TICKS) ? ERASE_TICKS : PROG_TICKS;
  localparam int CW = $clog2(MAX_TICKS + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign expire_o = run_i && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= '0;
    end else if (clear_i) begin
      cnt <= '0;
      lim <= erase_i ? CW'(ERASE_TICKS - 1) : CW'(PROG_TICKS - 1);
    end else if (run_i && !expire_o) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ndw_settle.sv
module ndw_settle #(
  parameter int CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  assign last_o = en_i && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (clr_i)       cnt <= '0;
    else if (en_i && !last_o) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ndw_ready_src.sv
module ndw_ready_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_present_i,
  input  logic rb_i,
  input  logic poll_i,
  input  logic st_valid_i,
  input  logic st_rdy_bit_i,
  output logic take_o,
  output logic ready_o
);
  logic rb_sync;

  ndw_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (rb_i),
    .q_o  (rb_sync)
  );

  assign take_o  = poll_i && !rb_present_i;
  assign ready_o = rb_present_i ? rb_sync : (st_valid_i && st_rdy_bit_i);
endmodule

// File: rtl/nand_done_waiter.sv
module nand_done_waiter
  import ndw_pkg::*;
#(
  parameter int TICKS_PER_MS   = 100000,
  parameter int PROG_MS        = 20,
  parameter int ERASE_MS       = 400,
  parameter int TWB_CYCLES     = 10,
  parameter int RB_SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       erase_i,
  input  logic       multi_status_i,
  input  logic       rb_present_i,
  input  logic       rb_i,
  output logic       cmd_valid_o,
  input  logic       cmd_ready_i,
  output logic [7:0] cmd_byte_o,
  input  logic       st_valid_i,
  output logic       st_ready_o,
  input  logic [7:0] st_byte_i,
  output logic       done_o,
  output logic [7:0] result_o
);
  localparam int PROG_TICKS  = PROG_MS * TICKS_PER_MS;
  localparam int ERASE_TICKS = ERASE_MS * TICKS_PER_MS;

  ndw_state_e state;
  logic [7:0] opc_q;
  logic [7:0] res_q;
  logic       accept;
  logic       timed;
  logic       tmo;
  logic       settle_last;
  logic       poll_take;
  logic       seen_ready;

  assign accept = (state == ST_IDLE) && start_i;
  assign timed  = (state == ST_ISSUE) || (state == ST_SETTLE) || (state == ST_POLL);

  ndw_timeout #(
    .PROG_TICKS (PROG_TICKS),
    .ERASE_TICKS(ERASE_TICKS)
  ) u_timeout (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .erase_i (erase_i),
    .run_i   (timed),
    .expire_o(tmo)
  );

  ndw_settle #(.CYCLES(TWB_CYCLES)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cmd_valid_o && cmd_ready_i),
    .en_i  (state == ST_SETTLE),
    .last_o(settle_last)
  );

  ndw_ready_src #(.SYNC_STAGES(RB_SYNC_STAGES)) u_ready (
    .clk         (clk),
    .rst_n       (rst_n),
    .rb_present_i(rb_present_i),
    .rb_i        (rb_i),
    .poll_i      (state == ST_POLL),
    .st_valid_i  (st_valid_i),
    .st_rdy_bit_i(st_byte_i[RDY_BIT]),
    .take_o      (poll_take),
    .ready_o     (seen_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      opc_q <= '0;
      res_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            opc_q <= pick_opcode(erase_i, multi_status_i);
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (tmo) begin
            res_q <= RES_TIMEOUT;
            state <= ST_REPORT;
          end else if (cmd_ready_i) begin
            state <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (tmo) begin
            res_q <= RES_TIMEOUT;
            state <= ST_REPORT;
          end else if (settle_last) begin
            state <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (tmo) begin
            res_q <= RES_TIMEOUT;
            state <= ST_REPORT;
          end else if (seen_ready) begin
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (st_valid_i) begin
            res_q <= st_byte_i;
            state <= ST_REPORT;
          end
        end
        ST_REPORT: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (state == ST_ISSUE);
  assign cmd_byte_o  = opc_q;
  assign st_ready_o  = poll_take || (state == ST_FETCH);
  assign done_o      = (state == ST_REPORT);
  assign result_o    = res_q;
endmodule

// File: rtl/ndw_chk.sv
module ndw_chk #(
  parameter int TWB_CYCLES = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       erase_i,
  input logic       multi_status_i,
  input logic       rb_present_i,
  input logic       cmd_valid_o,
  input logic       cmd_ready_i,
  input logic [7:0] cmd_byte_o,
  input logic       st_valid_i,
  input logic       st_ready_o,
  input logic       done_o
);
  logic        busy;
  logic        issued;
  logic        lat_erase;
  logic        lat_multi;
  logic [31:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      issued    <= 1'b0;
      lat_erase <= 1'b0;
      lat_multi <= 1'b0;
      age       <= '0;
    end else if (!busy) begin
      if (start_i) begin
        busy      <= 1'b1;
        issued    <= 1'b0;
        lat_erase <= erase_i;
        lat_multi <= multi_status_i;
        age       <= '0;
      end
    end else begin
      age <= age + 1'b1;
      if (cmd_valid_o && cmd_ready_i) issued <= 1'b1;
      if (done_o) busy <= 1'b0;
    end
  end

  assert_cmd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_byte_o));

  assert_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> cmd_byte_o == ((lat_erase && lat_multi) ? 8'h71 : 8'h70));

  assert_settle_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy && (age >= 32'(TWB_CYCLES + 3)));

  assert_final_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rb_present_i && st_valid_i && st_ready_o |=> done_o);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_single_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_ready_i |-> busy && !issued);
endmodule

bind nand_done_waiter ndw_chk #(.TWB_CYCLES(TWB_CYCLES)) u_ndw_chk (.*);

// File: tb/test_nand_done_waiter.sv
module test_nand_done_waiter;
  localparam int CLK_PERIOD = 10;
  localparam int TPM   = 10;
  localparam int TWB   = 3;
  localparam int SYNC  = 2;
  localparam int PLIM  = 20 * TPM;
  localparam int ELIM  = 400 * TPM;
  localparam int NEVER = 1 << 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, erase_i = 1'b0, multi_status_i = 1'b0;
  logic rb_present_i = 1'b0, rb_i = 1'b0;
  logic cmd_valid_o, cmd_ready_i = 1'b0;
  logic [7:0] cmd_byte_o;
  logic st_valid_i = 1'b0, st_ready_o;
  logic [7:0] st_byte_i = 8'h00;
  logic done_o;
  logic [7:0] result_o;

  nand_done_waiter #(
    .TICKS_PER_MS(TPM), .PROG_MS(20), .ERASE_MS(400),
    .TWB_CYCLES(TWB), .RB_SYNC_STAGES(SYNC)
  ) i_nand_done_waiter (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit mon_on = 1'b0;

  // scenario description (edge numbers)
  int sc_e0 = -100, sc_ec = -100, sc_d = -100, sc_er = NEVER;
  int sc_x1 = -1, sc_x2 = -1;
  bit sc_erase = 0, sc_multi = 0, sc_pin = 0;
  logic [7:0] sc_final = 8'h40, sc_busy = 8'h81, sc_op = 8'h70, sc_res = 8'h00;
  string sc_tag = "R5";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // input driver: value set after edge n applies to edge n+1
  always @(negedge clk) begin
    start_i        <= (cyc + 1 == sc_e0) || (cyc + 1 == sc_x1) || (cyc + 1 == sc_x2);
    erase_i        <= (cyc + 1 == sc_e0) ? sc_erase : !sc_erase;
    multi_status_i <= (cyc + 1 == sc_e0) ? sc_multi : !sc_multi;
    cmd_ready_i    <= (cyc + 1 >= sc_ec);
    rb_present_i   <= sc_pin;
    rb_i           <= sc_pin ? (cyc + 1 >= sc_er) : 1'b1;
    st_valid_i     <= 1'b1;
    st_byte_i      <= (sc_pin || (cyc + 1 >= sc_er)) ? sc_final : sc_busy;
  end

  // cycle-by-cycle comparison against the reference timeline
  always @(negedge clk) begin
    if (mon_on) begin
      bit exp_cv, exp_dn;
      exp_cv = (cyc >= sc_e0) && (cyc < sc_ec);
      exp_dn = (cyc == sc_d);
      chk(cmd_valid_o == exp_cv, "R1 cmd_valid", int'(cmd_valid_o), int'(exp_cv));
      if (exp_cv) chk(cmd_byte_o == sc_op, "R2 opcode", cmd_byte_o, sc_op);
      chk(done_o == exp_dn, "R8 done pulse", int'(done_o), int'(exp_dn));
      if (exp_dn) chk(result_o == sc_res, {sc_tag, " result"}, result_o, sc_res);
    end
  end

  task automatic run(input bit erase, input bit multi, input bit pin, input int stall,
                     input int rel_er, input logic [7:0] fin, input int x1rel,
                     input bit x_done, input string tag);
    int e0, ec, pp, eq, et, er_eff;
    @(posedge clk); #1;
    e0 = cyc + 2;
    ec = e0 + 1 + stall;
    pp = ec + TWB + 1;
    sc_er = (rel_er >= NEVER) ? NEVER : e0 + rel_er;
    er_eff = pin ? sc_er + SYNC : sc_er;
    eq = (er_eff > pp) ? er_eff : pp;
    et = e0 + (erase ? ELIM : PLIM);
    sc_erase = erase; sc_multi = multi; sc_pin = pin; sc_final = fin;
    sc_op = (erase && multi) ? 8'h71 : 8'h70;
    if (et <= eq) begin sc_d = et; sc_res = 8'h01; end
    else          begin sc_d = eq + 1; sc_res = fin; end
    sc_e0 = e0; sc_ec = ec; sc_tag = tag;
    sc_x1 = (x1rel > 0) ? e0 + x1rel : -1;
    sc_x2 = x_done ? sc_d + 1 : -1;
    while (cyc < sc_d + 4) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done", int'(done_o), 0);
    chk(cmd_valid_o == 1'b0, "R10 cmd_valid", int'(cmd_valid_o), 0);
    chk(st_ready_o == 1'b0, "R10 st_ready", int'(st_ready_o), 0);
    chk(result_o == 8'h00, "R10 result", result_o, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    run(0, 0, 0, 0, 30,    8'h40, 0, 0, "R5");   // status poll, program
    run(0, 0, 1, 0, 20,    8'hC1, 0, 0, "R4");   // pin mode; bit6 in bytes ignored
    run(1, 1, 1, 4, 1000,  8'h41, 0, 0, "R2");   // multi opcode, stalled cmd, past program window
    run(0, 1, 1, 0, -5,    8'h40, 0, 0, "R3");   // already ready: settle floor, opcode 0x70
    run(0, 0, 0, 0, 199,   8'h60, 0, 0, "R7");   // ready one edge before window end
    run(0, 0, 0, 0, 200,   8'h60, 0, 0, "R7");   // tie: timeout wins, 0x01
    run(0, 0, 1, 0, NEVER, 8'h40, 0, 0, "R7");   // program timeout via pin
    run(1, 0, 0, 0, NEVER, 8'h40, 0, 0, "R7");   // erase timeout, opcode 0x70
    run(0, 0, 0, 2, 50,    8'h44, 10, 1, "R9");  // starts while busy and in done cycle
    run(1, 1, 0, 0, 3000,  8'h42, 0, 0, "R6");   // erase, final byte passes through
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule